// File: doc/BRIEF.md
# Iterative SHA-256 Compression Engine

This block applies the SHA-256 compression function to one 512-bit message block per command, computing one round per clock cycle across all 64 rounds. The caller pads the message and splits it into blocks before handing them over. The block's 16 big-endian words are placed on `blockIn`. The caller then pulses `startMsg` for the first block of a message or `contMsg` for each block after it. `startMsg` first reloads the eight chaining registers with the standard SHA-256 initial values. `contMsg` continues from the digest already held in those registers.

The message schedule is not precomputed. It is generated as the rounds run, from a 16-word window that shifts by one word per round. The round constant is chosen by the round counter. After the last round, each of the eight working variables is added modulo 2^32 to its chaining register, and the sums become the new digest. `ready` reports that the engine is idle, and `digestValid` reports that the digest belongs to the current message.

Top module: `sha256_iter_core`

## Requirements
- R1: After reset, `ready` is 1 and `digestValid` is 0.
- R2: A `startMsg` command loads the standard initial hash values before compressing. The padded "abc" block (first word 0x61626380, last word 0x00000018, all other words zero) yields digest BA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD.
- R3: A `contMsg` command chains from the current digest. For the 56-byte two-block test message, the first block under `startMsg` yields 85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A. The second block (all words zero except the last, 0x000001C0) under `contMsg` then yields 248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1.
- R4: `ready` is 0 from the first clock edge after an accepted command. It returns to 1 exactly 65 clock edges after the accepting edge. While `ready` is 0, the round counter advances by one per cycle.
- R5: `digestValid` is cleared by an accepted `startMsg`. It is set by the final addition of every block. It stays set throughout a `contMsg` block.
- R6: A `startMsg` or `contMsg` that arrives while `ready` is 0 is ignored, including during the final-addition cycle. The running block's digest and latency are unchanged.
- R7: If `startMsg` and `contMsg` are both high in the same accepted cycle, `startMsg` takes priority and the initial values are used.
- R8: Word order is big-endian. `blockIn[511:480]` is schedule word 0, and `digestOut[255:224]` is chaining word H0.
- R9: `digestOut` changes only when initial values are loaded or when a final addition is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startMsg | input | 1 | Pulse: begin a new message with this block |
| contMsg | input | 1 | Pulse: chain this block onto the current digest |
| blockIn | input | 512 | Padded message block; must be held until `ready` returns |
| ready | output | 1 | Engine idle and accepting a command |
| digestOut | output | 256 | Chaining registers H0..H7, with H0 in the top word |
| digestValid | output | 1 | Digest is the result of a completed block |

## Verification
The hardest case to reach from the ports is a command arriving during the single final-addition cycle. In that cycle `ready` is still 0, but the round counter has already stopped. The bench counts negative edges after the command and raises both command pulses so that the edge which performs the addition samples them. It does the same at an earlier mid-round edge. In both runs it checks that the digest and the 65-edge latency are unchanged. Chaining and the start-over-continue priority are exercised by issuing commands back to back. This leaves a non-initial digest in the chaining registers, so a wrong choice produces a different, detectable result.

// File: rtl/sha256_iter_pkg.sv
package sha256_iter_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 8;
  localparam int SCHED_LEN  = 16;
  localparam int NUM_ROUNDS = 64;
  localparam int BLOCK_W    = WORD_W * SCHED_LEN;
  localparam int DIGEST_W   = WORD_W * NUM_WORDS;
  localparam int ROUND_W    = $clog2(NUM_ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic loadIv;
    logic loadWork;
    logic doRound;
    logic finalAdd;
  } ctrlStrobes_t;

  localparam word_t IV_TAB [NUM_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam word_t K_TAB [NUM_ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t smallSig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smallSig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sha256_iter_ctrl.sv
module sha256_iter_ctrl
  import sha256_iter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startMsg,
  input  logic               contMsg,
  output ctrlStrobes_t       strobes,
  output logic [ROUND_W-1:0] roundIdx,
  output logic               ready
);
  localparam logic [ROUND_W-1:0] LAST_ROUND = ROUND_W'(NUM_ROUNDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ROUNDS, ST_DONE} ctrlState_t;
  ctrlState_t state;
  logic accept;

  assign accept = (state == ST_IDLE) && (startMsg || contMsg);

  always_comb begin
    strobes.loadIv   = accept && startMsg;
    strobes.loadWork = accept;
    strobes.doRound  = (state == ST_ROUNDS);
    strobes.finalAdd = (state == ST_DONE);
  end

  assign ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      roundIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_ROUNDS;
          roundIdx <= '0;
        end
        ST_ROUNDS: begin
          if (roundIdx == LAST_ROUND) state <= ST_DONE;
          else roundIdx <= roundIdx + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: an accepted command takes the engine busy on the next cycle
  a_r4_cmd_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (ready && (startMsg || contMsg)) |=> !ready);

  // R6: commands during rounds never disturb the round count
  a_r6_round_steps: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doRound && roundIdx != LAST_ROUND) |=> (roundIdx == $past(roundIdx) + 1'b1));

  // R4: the final round is followed by the addition cycle, then idle
  a_r4_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finalAdd |=> ready);
endmodule

// File: rtl/sha256_iter_datapath.sv
module sha256_iter_datapath
  import sha256_iter_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [ROUND_W-1:0]  roundIdx,
  input  logic [BLOCK_W-1:0]  blockIn,
  output logic [DIGEST_W-1:0] digestOut,
  output logic                digestValid
);
  word_t hReg   [NUM_WORDS];
  word_t work   [NUM_WORDS];
  word_t sched  [SCHED_LEN];
  word_t t1, t2, kNow, wNext;
  word_t chFn, majFn;

  assign kNow  = K_TAB[roundIdx];
  assign chFn  = (work[4] & work[5]) ^ (~work[4] & work[6]);
  assign majFn = (work[0] & work[1]) ^ (work[0] & work[2]) ^ (work[1] & work[2]);
  assign t1    = work[7] + bigSig1(work[4]) + chFn + kNow + sched[0];
  assign t2    = bigSig0(work[0]) + majFn;
  assign wNext = smallSig1(sched[14]) + sched[9] + smallSig0(sched[1]) + sched[0];

  // Chaining registers and digest view
  genvar gi;
  generate
    for (gi = 0; gi < NUM_WORDS; gi++) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hReg[gi] <= '0;
        else if (strobes.loadIv) hReg[gi] <= IV_TAB[gi];
        else if (strobes.finalAdd) hReg[gi] <= hReg[gi] + work[gi];
      end
      assign digestOut[DIGEST_W-1-gi*WORD_W -: WORD_W] = hReg[gi];
    end

    for (gi = 0; gi < SCHED_LEN; gi++) begin : g_sched
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) sched[gi] <= '0;
        else if (strobes.loadWork) sched[gi] <= blockIn[BLOCK_W-1-gi*WORD_W -: WORD_W];
        else if (strobes.doRound) begin
          if (gi == SCHED_LEN - 1) sched[gi] <= wNext;
          else sched[gi] <= sched[(gi + 1) % SCHED_LEN];
        end
      end
    end
  endgenerate

  // Working variables a..h
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) work[i] <= '0;
    end else if (strobes.loadWork) begin
      for (int i = 0; i < NUM_WORDS; i++) work[i] <= strobes.loadIv ? IV_TAB[i] : hReg[i];
    end else if (strobes.doRound) begin
      work[0] <= t1 + t2;
      work[1] <= work[0];
      work[2] <= work[1];
      work[3] <= work[2];
      work[4] <= work[3] + t1;
      work[5] <= work[4];
      work[6] <= work[5];
      work[7] <= work[6];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) digestValid <= 1'b0;
    else if (strobes.loadIv) digestValid <= 1'b0;
    else if (strobes.finalAdd) digestValid <= 1'b1;
  end

  // R5: a finished block always leaves the digest flagged valid
  a_r5_valid_after_add: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finalAdd |=> digestValid);

  // R5: starting a message withdraws the valid flag
  a_r5_start_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIv |=> !digestValid);

  // R9: digest holds unless loaded or accumulated
  a_r9_digest_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadIv || strobes.finalAdd) |=> $stable(digestOut));

  // R2: a start command places the initial values in the top chaining word
  a_r2_iv_top_word: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIv |=> (digestOut[DIGEST_W-1 -: WORD_W] == 32'h6a09e667));
endmodule

// File: rtl/sha256_iter_core.sv
module sha256_iter_core
  import sha256_iter_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startMsg,
  input  logic                contMsg,
  input  logic [BLOCK_W-1:0]  blockIn,
  output logic                ready,
  output logic [DIGEST_W-1:0] digestOut,
  output logic                digestValid
);
  ctrlStrobes_t       strobes;
  logic [ROUND_W-1:0] roundIdx;

  sha256_iter_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startMsg (startMsg),
    .contMsg  (contMsg),
    .strobes  (strobes),
    .roundIdx (roundIdx),
    .ready    (ready)
  );

  sha256_iter_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .roundIdx    (roundIdx),
    .blockIn     (blockIn),
    .digestOut   (digestOut),
    .digestValid (digestValid)
  );
endmodule

// File: tb/sha256_iter_core_tb.sv
`timescale 1ns/1ps
module sha256_iter_core_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startMsg = 1'b0;
  logic         contMsg = 1'b0;
  logic [511:0] blockIn = '0;
  logic         ready;
  logic [255:0] digestOut;
  logic         digestValid;

  int testCnt = 0;
  int failCnt = 0;
  localparam int LAT = 66; // negedges after command until ready seen high (65 edges after accept)

  localparam logic [511:0] BLK_ABC = {32'h61626380, 448'h0, 32'h00000018};
  localparam logic [255:0] DIG_ABC = 256'hBA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD;
  localparam logic [511:0] BLK_L1  = 512'h6162636462636465636465666465666765666768666768696768696A68696A6B696A6B6C6A6B6C6D6B6C6D6E6C6D6E6F6D6E6F706E6F70718000000000000000;
  localparam logic [255:0] DIG_L1  = 256'h85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A;
  localparam logic [511:0] BLK_L2  = {480'h0, 32'h000001C0};
  localparam logic [255:0] DIG_L2  = 256'h248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1;

  always #2 clk = ~clk;

  sha256_iter_core u_dut (
    .clk(clk), .rstN(rstN), .startMsg(startMsg), .contMsg(contMsg),
    .blockIn(blockIn), .ready(ready), .digestOut(digestOut), .digestValid(digestValid));

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue a command; optionally raise both command pulses at negedge index pokeAt while busy
  task automatic runBlock(input logic [511:0] blk, input logic s, input logic c, input int pokeAt,
                          output int edges, output logic readyEarly, output logic validEarly);
    @(negedge clk);
    blockIn = blk; startMsg = s; contMsg = c;
    @(negedge clk);
    startMsg = 1'b0; contMsg = 1'b0;
    readyEarly = ready; validEarly = digestValid;
    edges = 1;
    while (!ready && edges < 200) begin
      if (edges + 1 == pokeAt) begin
        @(negedge clk); edges++;
        startMsg = 1'b1; contMsg = 1'b1;
      end else begin
        @(negedge clk); edges++;
        startMsg = 1'b0; contMsg = 1'b0;
      end
    end
    startMsg = 1'b0; contMsg = 1'b0;
  endtask

  task automatic testReset();
    check("R1 ready after reset", {255'h0, ready}, 256'h1);
    check("R1 valid after reset", {255'h0, digestValid}, 256'h0);
  endtask

  task automatic testAbc();
    int e; logic rE, vE;
    runBlock(BLK_ABC, 1'b1, 1'b0, -1, e, rE, vE);
    check("R2 R8 abc digest", digestOut, DIG_ABC);
    check("R4 ready low after accept", {255'h0, rE}, 256'h0);
    check("R4 latency", 256'(e), 256'(LAT));
    check("R5 valid set after block", {255'h0, digestValid}, 256'h1);
  endtask

  task automatic testChain();
    int e; logic rE, vE;
    runBlock(BLK_L1, 1'b1, 1'b0, -1, e, rE, vE);
    check("R5 start clears valid", {255'h0, vE}, 256'h0);
    check("R3 first block digest", digestOut, DIG_L1);
    runBlock(BLK_L2, 1'b0, 1'b1, -1, e, rE, vE);
    check("R5 valid held during cont", {255'h0, vE}, 256'h1);
    check("R3 chained digest", digestOut, DIG_L2);
    check("R4 cont latency", 256'(e), 256'(LAT));
  endtask

  task automatic testBusyIgnore(input int pokeAt);
    int e; logic rE, vE;
    runBlock(BLK_ABC, 1'b1, 1'b0, pokeAt, e, rE, vE);
    check($sformatf("R6 digest with poke at %0d", pokeAt), digestOut, DIG_ABC);
    check($sformatf("R6 latency with poke at %0d", pokeAt), 256'(e), 256'(LAT));
    @(negedge clk);
    check("R6 no restart after poke", {255'h0, ready}, 256'h1);
  endtask

  task automatic testPriority();
    int e; logic rE, vE;
    runBlock(BLK_L1, 1'b1, 1'b0, -1, e, rE, vE);
    runBlock(BLK_ABC, 1'b1, 1'b1, -1, e, rE, vE);
    check("R7 start wins over cont", digestOut, DIG_ABC);
  endtask

  task automatic testHold();
    logic [255:0] snap;
    snap = digestOut;
    repeat (10) @(negedge clk);
    check("R9 digest held while idle", digestOut, snap);
    check("R8 top word is H0", {224'h0, digestOut[255:224]}, {224'h0, DIG_ABC[255:224]});
  endtask

  initial begin
    #(200000 * 4);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAbc();
    testChain();
    testBusyIgnore(10);
    testBusyIgnore(65);
    testPriority();
    testHold();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule